// File: doc/BRIEF.md
# Video Memory Wait-State Generator

This block stalls processor accesses to a display adapter's video RAM. It runs from one dot clock, the fastest clock on the adapter, and derives the processor-cycle phase (3 dots) and the wide-character phase (16 dots) from free-running counters. When the processor asks for video memory at the start of one of its cycles, the block drops `ready_o` and releases it later, after a three-stage rule. First it lets a full narrow character (8 dots) pass. Then it waits for a wide-character boundary that lies strictly after that. Finally it waits for the next processor-cycle boundary, which may be that same dot.

The stall length therefore depends on where the processor cycle starts inside the 16-dot wide character. It ranges from 3 to 8 processor cycles. Over the 16 possible start positions, one gives 3 cycles and each of 4, 5, 6, 7 and 8 occurs three times, so the mean is 5.8125 cycles. The rule applies the same way at every raster position, retrace and overscan included, because the display scan also refreshes the video DRAM. When a stall ends, `wait_len_o` reports its length in processor cycles for debugging.

Top module: `vram_wait_gen`

## Requirements
- R1: While `rst_n` is low, `ready_o` is 1 and `wait_len_o` is 0. Reset is asynchronous and also aborts a stall in progress.
- R2: A request is accepted when `req_i` is 1 at a processor-cycle boundary dot (processor phase 0) while `ready_o` is 1. `ready_o` is 0 on the next dot.
- R3: A request at any dot whose processor phase is not 0 is ignored, and `ready_o` stays 1.
- R4: For a request accepted at dot t0 with wide phase p, `ready_o` returns to 1 at dot t3. Here t3 is the first processor boundary at or after t2, and t2 is the first wide boundary (wide phase 0) with t2 > t0+8. The stall is N = (t3-t0)/3 cycles, so `ready_o` is 0 for exactly 3N-1 dots.
- R5: N lies in 3..8. Over the 16 values of p, N=3 occurs once and each of 4, 5, 6, 7 and 8 occurs three times.
- R6: A request made while `ready_o` is 0 is ignored. It neither lengthens the current stall nor starts another one.
- R7: On the dot where `ready_o` returns to 1, `wait_len_o` holds N. It keeps that value until the next stall completes.
- R8: `ready_o` rises only on a dot whose processor phase is 0.
- R9: A request on the very dot where `ready_o` returns to 1 is accepted and starts a new stall, timed from that dot's wide phase.
- R10: Both phase counters run freely from reset. Dot k after reset release (dot 0 being the first) has processor phase (CPU_OFS+k) mod 3 and wide phase (WIDE_OFS+k) mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dot | input | 1 | Dot clock; every register is updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Processor video-memory request, one dot wide, aligned to a processor-cycle start |
| ready_o | output | 1 | 1 = processor may proceed, 0 = wait state in force |
| wait_len_o | output | LEN_W | Length in processor cycles of the last completed stall |

## Verification
The bench sweeps all 16 wide-character phases and checks the 1/3/3/3/3/3 histogram. A design that takes the wide boundary at or after t0+8, instead of strictly after it, would give 3 cycles twice and 8 cycles only twice, and this check would catch it. It fires a request on the release dot to catch a block that needs an extra idle dot before it accepts again. It also fires a request in the middle of a stall, which a block that restarts its count would stretch past 24 dots. A request off the processor boundary, a reset in the middle of a stall, and the first request after reset test the phase-ignore rule, the abort, and the counter start-up offsets.

// File: rtl/vws_pkg.sv
package vws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_NCHAR  = 2'd1,
    ST_WALIGN = 2'd2,
    ST_CALIGN = 2'd3
  } stall_st_e;

endpackage

// File: rtl/vws_phase_gen.sv
module vws_phase_gen #(
  parameter int CPU_DIV  = 3,
  parameter int WIDE_DIV = 16,
  parameter int CPU_OFS  = 0,
  parameter int WIDE_OFS = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cyc_now_o,
  output logic cyc_next_o,
  output logic wide_next_o
);

  localparam int CPU_W  = (CPU_DIV  > 1) ? $clog2(CPU_DIV)  : 1;
  localparam int WIDE_W = (WIDE_DIV > 1) ? $clog2(WIDE_DIV) : 1;
  localparam logic [CPU_W-1:0]  CPU_LAST  = CPU_W'(CPU_DIV - 1);
  localparam logic [WIDE_W-1:0] WIDE_LAST = WIDE_W'(WIDE_DIV - 1);
  localparam logic [CPU_W-1:0]  CPU_INIT  = CPU_W'(CPU_OFS % CPU_DIV);
  localparam logic [WIDE_W-1:0] WIDE_INIT = WIDE_W'(WIDE_OFS % WIDE_DIV);
  localparam bit WIDE_POW2 = ((WIDE_DIV & (WIDE_DIV - 1)) == 0);

  logic [CPU_W-1:0]  cpu_ph;
  logic [WIDE_W-1:0] wide_ph;

  // processor-cycle phase, modulo CPU_DIV
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cpu_ph <= CPU_INIT;
    else if (cpu_ph == CPU_LAST) cpu_ph <= '0;
    else                        cpu_ph <= cpu_ph + CPU_W'(1);
  end

  // wide-character phase: natural wrap when the period is a power of two
  generate
    if (WIDE_POW2) begin : g_wide_pow2
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) wide_ph <= WIDE_INIT;
        else         wide_ph <= wide_ph + WIDE_W'(1);
      end
    end else begin : g_wide_mod
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   wide_ph <= WIDE_INIT;
        else if (wide_ph == WIDE_LAST) wide_ph <= '0;
        else                           wide_ph <= wide_ph + WIDE_W'(1);
      end
    end
  endgenerate

  assign cyc_now_o   = (cpu_ph == '0);
  assign cyc_next_o  = (cpu_ph == CPU_LAST);
  assign wide_next_o = (wide_ph == WIDE_LAST);

  p_cpu_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ph == CPU_LAST) |=> (cpu_ph == '0));

  p_wide_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_ph == WIDE_LAST) |=> (wide_ph == '0));

endmodule

// File: rtl/vws_stall_fsm.sv
module vws_stall_fsm
  import vws_pkg::*;
#(
  parameter int NCHAR = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic cyc_now_i,
  input  logic cyc_next_i,
  input  logic wide_next_i,
  output logic busy_o,
  output logic start_o,
  output logic done_o
);

  localparam int EL_W = $clog2(NCHAR + 1);
  localparam logic [EL_W-1:0] EL_LAST = EL_W'(NCHAR);

  stall_st_e       state, state_nx;
  logic [EL_W-1:0] elapsed, elapsed_nx;

  assign start_o = (state == ST_IDLE) && req_i && cyc_now_i;

  // decisions look at the phase of the coming dot so that ready
  // changes exactly on the dot that qualifies
  always_comb begin
    state_nx   = state;
    elapsed_nx = elapsed;
    unique case (state)
      ST_IDLE: begin
        if (start_o) begin
          state_nx   = ST_NCHAR;
          elapsed_nx = EL_W'(1);
        end
      end
      ST_NCHAR: begin
        if (elapsed == EL_LAST) begin
          if (wide_next_i) state_nx = cyc_next_i ? ST_IDLE : ST_CALIGN;
          else             state_nx = ST_WALIGN;
        end else begin
          elapsed_nx = elapsed + EL_W'(1);
        end
      end
      ST_WALIGN: begin
        if (wide_next_i) state_nx = cyc_next_i ? ST_IDLE : ST_CALIGN;
      end
      ST_CALIGN: begin
        if (cyc_next_i) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      elapsed <= '0;
    end else begin
      state   <= state_nx;
      elapsed <= elapsed_nx;
    end
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = busy_o && (state_nx == ST_IDLE);

  // a request during a stall never ends it early or restarts it
  p_busy_ignores_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i && !cyc_next_i) |=> busy_o);

  // the narrow-character stage always runs its full length first
  p_nchar_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_NCHAR && elapsed != EL_LAST) |=> (state == ST_NCHAR));

endmodule

// File: rtl/vws_wait_meter.sv
module vws_wait_meter #(
  parameter int LEN_W   = 4,
  parameter int MIN_LEN = 3,
  parameter int MAX_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             cyc_next_i,
  output logic [LEN_W-1:0] wait_len_o
);

  logic [LEN_W-1:0] run_cnt;

  // counts processor boundaries crossed since the accepted request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    run_cnt <= '0;
    else if (start_i)               run_cnt <= '0;
    else if (busy_i && cyc_next_i)  run_cnt <= run_cnt + LEN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wait_len_o <= '0;
    else if (done_i) wait_len_o <= run_cnt + LEN_W'(1);
  end

  p_len_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_len_o != '0) |-> (wait_len_o >= LEN_W'(MIN_LEN) && wait_len_o <= LEN_W'(MAX_LEN)));

  p_run_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (run_cnt < LEN_W'(MAX_LEN)));

endmodule

// File: rtl/vram_wait_gen.sv
module vram_wait_gen #(
  parameter int CPU_DIV  = 3,
  parameter int NCHAR    = 8,
  parameter int WIDE_DIV = 16,
  parameter int CPU_OFS  = 0,
  parameter int WIDE_OFS = 0,
  parameter int LEN_W    = 4
) (
  input  logic             clk_dot,
  input  logic             rst_n,
  input  logic             req_i,
  output logic             ready_o,
  output logic [LEN_W-1:0] wait_len_o
);

  localparam int MIN_LEN = (NCHAR + 1 + CPU_DIV - 1) / CPU_DIV;
  localparam int MAX_LEN = (NCHAR + WIDE_DIV + CPU_DIV - 1) / CPU_DIV;

  logic cyc_now, cyc_next, wide_next;
  logic busy, start, done;

  vws_phase_gen #(
    .CPU_DIV (CPU_DIV),
    .WIDE_DIV(WIDE_DIV),
    .CPU_OFS (CPU_OFS),
    .WIDE_OFS(WIDE_OFS)
  ) u_phase (
    .clk_i      (clk_dot),
    .rst_ni     (rst_n),
    .cyc_now_o  (cyc_now),
    .cyc_next_o (cyc_next),
    .wide_next_o(wide_next)
  );

  vws_stall_fsm #(
    .NCHAR(NCHAR)
  ) u_fsm (
    .clk_i      (clk_dot),
    .rst_ni     (rst_n),
    .req_i      (req_i),
    .cyc_now_i  (cyc_now),
    .cyc_next_i (cyc_next),
    .wide_next_i(wide_next),
    .busy_o     (busy),
    .start_o    (start),
    .done_o     (done)
  );

  vws_wait_meter #(
    .LEN_W  (LEN_W),
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN)
  ) u_meter (
    .clk_i     (clk_dot),
    .rst_ni    (rst_n),
    .start_i   (start),
    .busy_i    (busy),
    .done_i    (done),
    .cyc_next_i(cyc_next),
    .wait_len_o(wait_len_o)
  );

  assign ready_o = !busy;

  p_req_stalls_r2: assert property (@(posedge clk_dot) disable iff (!rst_n)
    (ready_o && req_i && cyc_now) |=> !ready_o);

  p_rise_on_edge_r8: assert property (@(posedge clk_dot) disable iff (!rst_n)
    $rose(ready_o) |-> cyc_now);

  p_off_phase_ignored_r3: assert property (@(posedge clk_dot) disable iff (!rst_n)
    (ready_o && !cyc_now) |=> ready_o);

endmodule

// File: tb/tb_vram_wait_gen.sv
module tb_vram_wait_gen;

  localparam int CPU_OFS  = 0;
  localparam int WIDE_OFS = 5;

  // {wide phase at request, expected stall in processor cycles}
  localparam logic [7:0] VEC [16] = '{
    8'h0_6, 8'h1_5, 8'h2_5, 8'h3_5, 8'h4_4, 8'h5_4, 8'h6_4, 8'h7_3,
    8'h8_8, 8'h9_8, 8'hA_8, 8'hB_7, 8'hC_7, 8'hD_7, 8'hE_6, 8'hF_6
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       ready;
  logic [3:0] wlen;

  int checks = 0;
  int errors = 0;
  int dot    = 0;
  int hist [16];

  vram_wait_gen #(
    .CPU_OFS (CPU_OFS),
    .WIDE_OFS(WIDE_OFS)
  ) dut (
    .clk_dot   (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .ready_o   (ready),
    .wait_len_o(wlen)
  );

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) dot <= 0;
    else        dot <= dot + 1;
  end

  function automatic int cpu_phase(int d);
    return (CPU_OFS + d) % 3;
  endfunction

  function automatic int wide_phase(int d);
    return (WIDE_OFS + d) % 16;
  endfunction

  function automatic int exp_len(int p);
    int x;
    x = 8 + 16 - ((p + 8) % 16);
    return (x + 2) / 3;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (dot %0d)", tag, act, exp, dot);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_phase(input int p);
    do @(negedge clk); while (!(cpu_phase(dot) == 0 && wide_phase(dot) == p));
  endtask

  // called at the first dot after acceptance; returns at the release dot
  task automatic measure(output int n);
    int low;
    low = 1;
    while (low < 64) begin
      @(negedge clk);
      if (ready) break;
      low++;
    end
    chk(low < 64, "R4 stall ends", low, 0);
    chk((low + 1) % 3 == 0, "R4 low dots = 3N-1", low, 0);
    chk(cpu_phase(dot) == 0, "R8 release on boundary", cpu_phase(dot), 0);
    n = (low + 1) / 3;
  endtask

  task automatic pulse_req();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    int m;
    int e;
    int p;
    int t0;
    int keep;
    for (int i = 0; i < 16; i++) hist[i] = 0;

    // R1: reset values
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1 ready in reset", ready, 1);
    chk(wlen == 4'd0, "R1 wait_len in reset", wlen, 0);

    // R10: first request on dot 0 uses the reset offsets
    rst_n = 1'b1;
    p = wide_phase(dot);
    pulse_req();
    chk(ready == 1'b0, "R2 ready drops", ready, 0);
    measure(m);
    chk(m == exp_len(p), "R10 first stall from offset phase", m, exp_len(p));

    // R4, R5, R7, R10: sweep every wide phase from the table
    for (int i = 0; i < 16; i++) begin
      p = int'(VEC[i][7:4]);
      e = int'(VEC[i][3:0]);
      wait_phase(p);
      pulse_req();
      chk(ready == 1'b0, "R2 ready drops", ready, 0);
      measure(m);
      chk(m == e, "R4 stall length", m, e);
      chk(int'(wlen) == e, "R7 wait_len", wlen, e);
      if (m >= 0 && m < 16) hist[m]++;
    end
    for (int n = 0; n < 16; n++) begin
      e = (n == 3) ? 1 : ((n >= 4 && n <= 8) ? 3 : 0);
      chk(hist[n] == e, $sformatf("R5 histogram bin %0d", n), hist[n], e);
    end

    // R7: value held while idle
    keep = int'(wlen);
    repeat (10) @(negedge clk);
    chk(int'(wlen) == keep && ready, "R7 wait_len held", wlen, keep);

    // R3: request off the processor boundary
    do @(negedge clk); while (cpu_phase(dot) != 1);
    pulse_req();
    m = 0;
    for (int k = 0; k < 12; k++) begin
      if (!ready) m++;
      @(negedge clk);
    end
    chk(m == 0, "R3 off-phase request ignored", m, 0);

    // R6: request during a stall
    wait_phase(8);
    t0 = dot;
    pulse_req();
    do @(negedge clk); while (cpu_phase(dot) != 0);
    chk(ready == 1'b0, "R6 still stalled", ready, 0);
    pulse_req();
    m = 0;
    while (!ready && m < 64) begin
      @(negedge clk);
      m++;
    end
    chk(dot == t0 + 24, "R6 stall not lengthened", dot - t0, 24);
    chk(wlen == 4'd8, "R6 wait_len unchanged rule", wlen, 8);
    m = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!ready) m++;
    end
    chk(m == 0, "R6 no second stall", m, 0);

    // R9: back-to-back request on the release dot
    wait_phase(0);
    pulse_req();
    measure(m);
    chk(m == 6, "R4 stall length phase 0", m, 6);
    p = wide_phase(dot);
    pulse_req();
    chk(ready == 1'b0, "R9 back-to-back accepted", ready, 0);
    measure(m);
    chk(m == exp_len(p), "R9 back-to-back length", m, exp_len(p));

    // R1: reset aborts a stall
    wait_phase(9);
    pulse_req();
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ready == 1'b1, "R1 reset aborts stall", ready, 1);
    chk(wlen == 4'd0, "R1 reset clears wait_len", wlen, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready == 1'b1, "R1 idle after reset", ready, 1);

    finish_run();
  end

endmodule